// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit

This block shifts or rotates a word in one pass through a logarithmic barrel network and presents the result one clock later. It covers logical left and right shifts, an arithmetic right shift that copies the sign bit into the vacated positions, and left and right rotates. The amount either comes from a count register operand or from a short immediate field. An immediate-mode select chooses between the two sources.

Shifts that take their count from the register look at one more count bit than the word needs. As a result, counts from one word width up to twice the width minus one push every data bit out of the word. Rotates that take their count from the register use only the bits needed to index a position in the word, so the amount wraps at the word width. An input valid strobe moves with the data. The output register loads only when that strobe is high.

Top module: `shf_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both `out_valid` and `result` are cleared to zero by the next edge.
- R2: `out_valid` equals `in_valid` delayed by one clock. `result` shows the outcome for the operands presented with `in_valid` high one clock earlier.
- R3: The `op` encoding is 0 logical left shift, 1 logical right shift, 2 arithmetic right shift, 3 rotate left and 4 rotate right. Codes 5, 6 and 7 are reserved and produce a zero result.
- R4: With `use_imm` low, a shift takes its amount from `cnt_reg[5:0]` (the count modulo 64). Bits 31 to 6 of `cnt_reg` have no effect.
- R5: A register-count shift whose amount is 32 to 63 gives all zeros for the logical shifts. For the arithmetic right shift it gives 32 copies of `data[31]`.
- R6: Logical shifts fill vacated positions with zeros. The arithmetic right shift fills them with `data[31]`.
- R7: With `use_imm` high, every operation takes its amount from the 5-bit `cnt_imm`, and `cnt_reg` has no effect.
- R8: With `use_imm` low, a rotate takes its amount from `cnt_reg[4:0]` only, so `cnt_reg[5]` has no effect. A rotate never changes the number of set bits.
- R9: A rotate by 0 returns the data unchanged. A right rotate by n gives the same word as a left rotate by (32 − n) mod 32.
- R10: While `in_valid` is low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| op | input | 3 | Operation select (see R3) |
| use_imm | input | 1 | 1: amount from `cnt_imm`; 0: amount from `cnt_reg` |
| data | input | 32 | Word to shift or rotate |
| cnt_reg | input | 32 | Count register operand |
| cnt_imm | input | 5 | Immediate amount field |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 32 | Registered result |

## Verification
Each stage of the barrel network either passes its word through or moves it by one power of two. A stuck stage select or a wrong fill source therefore corrupts exactly those amounts that have the matching count bit set, and the corruption appears on `result` in the cycle right after the operands are applied. Flush handling depends on a single count bit. A fault there shows only for counts of 32 to 63, or only when a rotate is given such a count, so those counts are driven on purpose against the reference model. The same model compares every clock, so a fault in the valid or hold logic shows one cycle after the first mismatched `in_valid`.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        OP_SLL = 3'd0,
        OP_SRL = 3'd1,
        OP_SRA = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4
    } shf_op_e;

    typedef struct packed {
        logic legal;
        logic left;
        logic rotate;
        logic arith;
    } shf_ctl_t;

    function automatic shf_ctl_t decode_op(input logic [2:0] code);
        shf_ctl_t c;
        c = '0;
        case (code)
            OP_SLL: begin c.legal = 1'b1; c.left = 1'b1; end
            OP_SRL: begin c.legal = 1'b1; end
            OP_SRA: begin c.legal = 1'b1; c.arith = 1'b1; end
            OP_ROL: begin c.legal = 1'b1; c.left = 1'b1; c.rotate = 1'b1; end
            OP_ROR: begin c.legal = 1'b1; c.rotate = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/shf_amount.sv
module shf_amount
    import shf_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  shf_ctl_t               ctl_i,
    input  logic                   use_imm_i,
    input  logic [W-1:0]           cnt_reg_i,
    input  logic [$clog2(W)-1:0]   cnt_imm_i,
    output logic [$clog2(W)-1:0]   amt_o,
    output logic                   flush_o
);
    localparam int unsigned AW = $clog2(W);
    localparam int unsigned RW = AW + 1;

    logic unused_cnt_hi;
    assign unused_cnt_hi = ^cnt_reg_i[W-1:RW];

    // Stage amount: immediate field or low count bits.
    assign amt_o = use_imm_i ? cnt_imm_i : cnt_reg_i[AW-1:0];

    // Extra count bit only matters for register-count shifts.
    assign flush_o = !use_imm_i && !ctl_i.rotate && cnt_reg_i[AW];
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
    import shf_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0]         data_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  logic                 left_i,
    input  logic                 rotate_i,
    input  logic                 arith_i,
    output logic [W-1:0]         data_o
);
    localparam int unsigned AW = $clog2(W);

    logic [AW:0][W-1:0] stage;
    logic               sign_fill;

    assign sign_fill = arith_i & data_i[W-1];
    assign stage[0]  = data_i;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int unsigned D = 1 << s;
        logic [D-1:0] lfill;
        logic [D-1:0] rfill;
        logic [W-1:0] lmove;
        logic [W-1:0] rmove;

        assign lfill = rotate_i ? stage[s][W-1 -: D] : '0;
        assign rfill = rotate_i ? stage[s][D-1:0]    : {D{sign_fill}};
        assign lmove = {stage[s][W-1-D:0], lfill};
        assign rmove = {rfill, stage[s][W-1:D]};
        assign stage[s+1] = amt_i[s] ? (left_i ? lmove : rmove) : stage[s];
    end

    assign data_o = stage[AW];
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [2:0]           op,
    input  logic                 use_imm,
    input  logic [W-1:0]         data,
    input  logic [W-1:0]         cnt_reg,
    input  logic [$clog2(W)-1:0] cnt_imm,
    output logic                 out_valid,
    output logic [W-1:0]         result
);
    localparam int unsigned AW = $clog2(W);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] val;
    } out_reg_t;

    shf_ctl_t      ctl;
    logic [AW-1:0] amt;
    logic          flush;
    logic [W-1:0]  moved;
    logic [W-1:0]  next_val;
    out_reg_t      q;

    assign ctl = decode_op(op);

    shf_amount #(.W(W)) u_amount (
        .ctl_i     (ctl),
        .use_imm_i (use_imm),
        .cnt_reg_i (cnt_reg),
        .cnt_imm_i (cnt_imm),
        .amt_o     (amt),
        .flush_o   (flush)
    );

    shf_barrel #(.W(W)) u_barrel (
        .data_i   (data),
        .amt_i    (amt),
        .left_i   (ctl.left),
        .rotate_i (ctl.rotate),
        .arith_i  (ctl.arith),
        .data_o   (moved)
    );

    always_comb begin
        if (!ctl.legal)
            next_val = '0;
        else if (flush)
            next_val = {W{ctl.arith & data[W-1]}};
        else
            next_val = moved;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_valid;
            if (in_valid)
                q.val <= next_val;
        end
    end

    assign out_valid = q.vld;
    assign result    = q.val;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    a_r2_valid_high: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_valid_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > 3'd4) |=> result == '0);

    a_r5_flush_logical: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_imm && (op == OP_SLL || op == OP_SRL) && cnt_reg[AW])
        |=> result == '0);

    a_r5_flush_arith: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_imm && op == OP_SRA && cnt_reg[AW])
        |=> result == {W{$past(data[W-1])}});

    a_r8_rotate_popcount: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_ROL || op == OP_ROR))
        |=> $countones(result) == $countones($past(data)));

    a_r9_rotate_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_ROL || op == OP_ROR) &&
         (use_imm ? (cnt_imm == '0) : (cnt_reg[AW-1:0] == '0)))
        |=> result == $past(data));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
endmodule

// File: tb/shf_unit_bench.sv
module shf_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op;
    logic        use_imm;
    logic [31:0] data;
    logic [31:0] cnt_reg;
    logic [4:0]  cnt_imm;
    logic        out_valid;
    logic [31:0] result;

    int          vectors = 0;
    int          miscompares = 0;
    logic        exp_valid;
    logic [31:0] exp_res;
    string       exp_tag;
    logic [31:0] hist0, hist1;

    always #4 clk = ~clk;

    shf_unit u_shf_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .use_imm(use_imm),
        .data(data), .cnt_reg(cnt_reg), .cnt_imm(cnt_imm),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] model(input logic [2:0] o, input logic im,
                                          input logic [31:0] d, input logic [31:0] cr,
                                          input logic [4:0] ci, output string tag);
        int n;
        logic signed [31:0] sd;
        logic [31:0] r;
        sd = d;
        n = im ? int'(ci) : ((o == 3'd3 || o == 3'd4) ? int'(cr[4:0]) : int'(cr[5:0]));
        case (o)
            3'd0: r = (n >= 32) ? 32'd0 : d << n;
            3'd1: r = (n >= 32) ? 32'd0 : d >> n;
            3'd2: r = (n >= 32) ? {32{d[31]}} : 32'(sd >>> n);
            3'd3: r = (n == 0) ? d : ((d << n) | (d >> (32 - n)));
            3'd4: r = (n == 0) ? d : ((d >> n) | (d << (32 - n)));
            default: r = 32'd0;
        endcase
        if (o > 3'd4)                  tag = "R3";
        else if (im)                   tag = "R7";
        else if (o <= 3'd2 && n >= 32) tag = "R5";
        else if (o == 3'd2)            tag = "R6";
        else if (o <= 3'd1)            tag = "R4";
        else if (n == 0)               tag = "R9";
        else                           tag = "R8";
        return r;
    endfunction

    task automatic compare();
        vectors++;
        if (out_valid !== exp_valid) begin
            miscompares++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
        end else if (result !== exp_res) begin
            miscompares++;
            $display("FAIL %s result actual=%08h expected=%08h", exp_tag, result, exp_res);
        end
        hist0 = hist1;
        hist1 = result;
    endtask

    task automatic step(input logic v, input logic [2:0] o, input logic im,
                        input logic [31:0] d, input logic [31:0] cr, input logic [4:0] ci);
        string t;
        logic [31:0] r;
        @(negedge clk);
        compare();
        in_valid = v; op = o; use_imm = im; data = d; cnt_reg = cr; cnt_imm = ci;
        r = model(o, im, d, cr, ci, t);
        exp_valid = v;
        if (v) begin
            exp_res = r;
            exp_tag = t;
        end else begin
            exp_tag = "R10";
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; op = 3'd0; use_imm = 1'b0;
        data = 32'hFFFF_FFFF; cnt_reg = 32'd1; cnt_imm = 5'd0;
        hist0 = '0; hist1 = '0;
        exp_valid = 1'b0; exp_res = '0; exp_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        // R1: reset state seen on first compare
        step(1, 3'd0, 0, 32'h8000_0001, 32'd4, 5'd0);            // R4 left shift
        step(1, 3'd1, 0, 32'h8000_0001, 32'hFFFF_FFC4, 5'd0);    // R4 high bits ignored
        step(1, 3'd2, 0, 32'h8000_0000, 32'd31, 5'd0);           // R6 sign fill
        step(1, 3'd1, 0, 32'h8000_0000, 32'd31, 5'd0);           // R6 zero fill
        step(1, 3'd0, 0, 32'hDEAD_BEEF, 32'd32, 5'd0);           // R5
        step(1, 3'd1, 0, 32'hDEAD_BEEF, 32'd63, 5'd0);           // R5
        step(1, 3'd2, 0, 32'h9000_0000, 32'd40, 5'd0);           // R5 arithmetic
        step(1, 3'd2, 0, 32'h7000_0000, 32'd33, 5'd0);           // R5 positive
        step(1, 3'd0, 1, 32'h0000_00FF, 32'd40, 5'd8);           // R7
        step(1, 3'd2, 1, 32'hF000_0000, 32'd0, 5'd31);           // R7
        step(1, 3'd3, 0, 32'h1234_5678, 32'd36, 5'd0);           // R8 bit5 ignored
        step(1, 3'd4, 0, 32'h1234_5678, 32'd32, 5'd0);           // R9 rotate by zero
        step(1, 3'd5, 0, 32'hFFFF_FFFF, 32'd1, 5'd0);            // R3 reserved
        step(1, 3'd7, 1, 32'hFFFF_FFFF, 32'd1, 5'd3);            // R3 reserved
        step(0, 3'd0, 0, 32'h0F0F_0F0F, 32'd2, 5'd0);            // R10 hold
        step(0, 3'd3, 1, 32'hAAAA_5555, 32'd2, 5'd1);            // R10 hold
        // R9: right rotate by n equals left rotate by 32-n
        for (int n = 1; n < 32; n += 5) begin
            step(1, 3'd4, 1, 32'hC0DE_1234, 32'd0, 5'(n));
            step(1, 3'd3, 1, 32'hC0DE_1234, 32'd0, 5'(32 - n));
            step(0, 3'd0, 0, 32'd0, 32'd0, 5'd0);
            vectors++;
            if (hist0 !== hist1) begin
                miscompares++;
                $display("FAIL R9 rol actual=%08h expected=%08h", hist1, hist0);
            end
        end
        // R2: mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            step(($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), $urandom(), $urandom(),
                 5'($urandom_range(0, 31)));
        end
        step(0, 3'd0, 0, 32'd0, 32'd0, 5'd0);
        @(negedge clk);
        compare();
        finish_run();
    end
endmodule